// File: doc/BRIEF.md
# Manchester Downlink Bit Decoder

This block turns an amplitude-detected, Manchester-coded serial line into bytes. The line comes from an analog comparator whose polarity is opposite to the data, so the block inverts it first. It then passes the line through a short synchronizer and watches for level changes. A transmission always opens with a 0 symbol. Decoding is therefore armed by the first rising edge of the decoded line after the start enable goes high. From then on, a counter measures the time since the last accepted mid-bit edge.

Each following mid-bit edge must fall inside a tolerance window centred on one bit period. The direction of that edge gives the bit value. Level changes that come earlier than the window are half-bit boundary changes, and the decoder ignores them. If the window closes with no edge, the reception is abandoned and an abort flag is raised. The partial byte is discarded and the decoder hunts for a new opening edge.

Bits are packed most significant bit first. Every eighth bit produces a new parallel byte and a one-cycle strobe. Dropping the start enable returns the block to its off state at once. The tolerance parameter must stay below half the bit period.

The controller has three states:
- `ST_OFF`: the enable is low.
- `ST_HUNT`: the decoder waits for the opening rising edge.
- `ST_TRACK`: the decoder times bit periods.

Its transitions are:
- OFF to HUNT when the enable rises.
- HUNT to TRACK on the first decoded rising edge.
- TRACK to HUNT on a window timeout.
- HUNT or TRACK to OFF whenever the enable is low.

Top module: `manchester_rx`

## Requirements
- R1: The raw input is inverted before decoding. On the decoded line, a rising mid-bit edge (a falling raw edge) is a 0 bit. A falling mid-bit edge (a rising raw edge) is a 1 bit.
- R2: While `start_en` is low, the block is in `ST_OFF`. Line activity produces no strobe, leaves `abort_flag` at 0 and leaves `byte_out` unchanged. After reset, all outputs are 0.
- R3: In `ST_HUNT`, only a decoded rising edge starts decoding. That edge is taken as the midpoint of a first bit of value 0. A decoded falling edge in `ST_HUNT` is ignored and starts no timing.
- R4: An edge is accepted as the next mid-bit edge when it arrives between BIT_CYC-TOL and BIT_CYC+TOL clock cycles after the previous accepted edge, both limits included. Edges that arrive earlier are ignored.
- R5: If no edge is accepted by BIT_CYC+TOL cycles after the previous accepted edge, then:
  - `abort_flag` is set,
  - the partial byte and the bit count are discarded,
  - the decoder returns to `ST_HUNT`.

  An edge that lands exactly on the last window cycle is accepted, not timed out.
- R6: Bits are shifted in most significant bit first. After the BYTE_W-th bit, `byte_out` takes the assembled byte and `byte_valid` is high for exactly one cycle. The next bit starts a new byte.
- R7: Timing restarts at each accepted edge, so an offset of TOL on every bit never accumulates into a timeout.
- R8: Deasserting `start_en` clears the partial byte, the bit count and `abort_flag` by the next clock edge.
- R9: `abort_flag` stays set while `start_en` remains high. The decoder can still re-arm and deliver later bytes while the flag is set.
- R10: `byte_out` changes only in the cycle in which `byte_valid` is high, and holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock recovered from the carrier |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_en | input | 1 | High while demodulation is enabled; low forces the off state |
| line_raw | input | 1 | Comparator output, inverted with respect to the data |
| byte_out | output | BYTE_W | Last completed byte, first received bit in the MSB |
| byte_valid | output | 1 | One-cycle strobe marking a new value on `byte_out` |
| abort_flag | output | 1 | Sticky indication that a bit window closed without an edge |

## Verification
The properties assume the following about the inputs:
- `start_en` is driven synchronously to `clk`.
- The line carries Manchester symbols whose half-bit plateaus are far longer than the synchronizer depth.
- Consecutive accepted mid-bit edges are therefore always many cycles apart, so strobes cannot touch.

The stimulus meets these assumptions. It changes inputs only at the falling clock edge and builds every symbol from plateaus of at least half a bit. Mid-bit edges move only by whole-cycle offsets, chosen at the window limits and one cycle outside them.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_HUNT,
        ST_TRACK
    } mrx_state_e;

endpackage

// File: rtl/mrx_edge.sv
module mrx_edge #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic rise,
    output logic fall
);

    logic [SYNC_N-1:0] sync_q;
    logic              prev_q;

    // Inversion happens at the synchronizer input; idle raw high reads as decoded low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], ~line_raw};
            prev_q <= sync_q[SYNC_N-1];
        end
    end

    assign rise = sync_q[SYNC_N-1] & ~prev_q;
    assign fall = ~sync_q[SYNC_N-1] & prev_q;

endmodule

// File: rtl/mrx_timer.sv
module mrx_timer #(
    parameter int BIT_CYC = 128,
    parameter int TOL     = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic load,
    input  logic run,
    output logic in_win,
    output logic expired
);

    localparam int            HI_I = BIT_CYC + TOL;
    localparam int            LO_I = BIT_CYC - TOL;
    localparam int            CW   = $clog2(HI_I + 1);
    localparam logic [CW-1:0] HI_C = CW'(HI_I);
    localparam logic [CW-1:0] LO_C = CW'(LO_I);

    logic [CW-1:0] cnt_q;

    // cnt_q holds the number of clock edges since the last accepted edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(1);
        end else if (run && (cnt_q != HI_C)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign in_win  = (cnt_q >= LO_C) && (cnt_q <= HI_C);
    assign expired = (cnt_q >= HI_C);

endmodule

// File: rtl/mrx_shift.sv
module mrx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word_next,
    output logic         last
);

    localparam int CNTW = $clog2(W);

    logic [W-1:0]    bits_q;
    logic [CNTW-1:0] cnt_q;

    assign word_next = {bits_q[W-2:0], bit_in};
    assign last      = (cnt_q == CNTW'(W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
            cnt_q  <= '0;
        end else if (clear) begin
            bits_q <= '0;
            cnt_q  <= '0;
        end else if (shift_en) begin
            bits_q <= word_next;
            cnt_q  <= last ? '0 : cnt_q + CNTW'(1);
        end
    end

endmodule

// File: rtl/manchester_rx.sv
module manchester_rx
    import mrx_pkg::*;
#(
    parameter int BIT_CYC = 128,
    parameter int TOL     = 16,
    parameter int BYTE_W  = 8,
    parameter int SYNC_N  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_en,
    input  logic              line_raw,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_valid,
    output logic              abort_flag
);

    mrx_state_e state_q, state_nxt;

    logic              rise, fall;
    logic              in_win, expired;
    logic              take_first, accept, timeout;
    logic              shift_en, bit_in, sh_clear, last;
    logic              tmr_clear;
    logic [BYTE_W-1:0] word_next;
    logic [BYTE_W-1:0] byte_q;
    logic              valid_q, abort_q;

    mrx_edge #(.SYNC_N(SYNC_N)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_raw (line_raw),
        .rise     (rise),
        .fall     (fall)
    );

    // Decision signals for the current cycle.
    always_comb begin
        take_first = (state_q == ST_HUNT) && start_en && rise;
        accept     = (state_q == ST_TRACK) && start_en && (rise || fall) && in_win;
        timeout    = (state_q == ST_TRACK) && start_en && expired && !accept;
        shift_en   = take_first || accept;
        bit_in     = accept && fall;
        sh_clear   = !start_en || timeout;
    end

    // Next-state logic.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (start_en) state_nxt = ST_HUNT;
            end
            ST_HUNT: begin
                if (!start_en)   state_nxt = ST_OFF;
                else if (rise)   state_nxt = ST_TRACK;
            end
            ST_TRACK: begin
                if (!start_en)    state_nxt = ST_OFF;
                else if (timeout) state_nxt = ST_HUNT;
            end
            default: state_nxt = ST_OFF;
        endcase
    end

    assign tmr_clear = (state_nxt != ST_TRACK);

    mrx_timer #(.BIT_CYC(BIT_CYC), .TOL(TOL)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .load    (shift_en),
        .run     (state_q == ST_TRACK),
        .in_win  (in_win),
        .expired (expired)
    );

    mrx_shift #(.W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (sh_clear),
        .shift_en  (shift_en),
        .bit_in    (bit_in),
        .word_next (word_next),
        .last      (last)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_nxt;
    end

    // Output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q  <= '0;
            valid_q <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            valid_q <= shift_en && last;
            if (shift_en && last) byte_q <= word_next;
            if (!start_en)     abort_q <= 1'b0;
            else if (timeout)  abort_q <= 1'b1;
        end
    end

    assign byte_out   = byte_q;
    assign byte_valid = valid_q;
    assign abort_flag = abort_q;

endmodule

// File: rtl/mrx_chk.sv
module mrx_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_en,
    input logic [W-1:0] byte_out,
    input logic         byte_valid,
    input logic         abort_flag
);

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    // R8
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_en |=> (!abort_flag && !byte_valid));

    // R9
    abort_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_flag && start_en) |=> abort_flag);

    // R2
    abort_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_flag) |-> $past(start_en));

    // R10
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |-> $stable(byte_out));

    // R5
    abort_vs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid && $rose(abort_flag)));

endmodule

bind manchester_rx mrx_chk #(.W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_en   (start_en),
    .byte_out   (byte_out),
    .byte_valid (byte_valid),
    .abort_flag (abort_flag)
);

// File: tb/manchester_rx_tb.sv
module manchester_rx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int BIT  = 128;
    localparam int TOL  = 16;
    localparam int HALF = BIT / 2;
    localparam int HI   = BIT + TOL;
    localparam int WD   = 100000;

    // {data byte, signed offset added to every mid-bit spacing after the first}
    localparam logic [15:0] VEC [0:4] = '{16'h3500, 16'h0010, 16'h7FF0, 16'h5A08, 16'h01FB};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_en = 1'b0;
    logic       line_raw = 1'b1;
    logic [7:0] byte_out;
    logic       byte_valid;
    logic       abort_flag;

    int         checks = 0;
    int         errors = 0;
    int         ncap = 0;
    int         pulse_bad = 0;
    logic       prev_v = 1'b0;
    logic [7:0] cap [4];
    bit         done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    manchester_rx #(.BIT_CYC(BIT), .TOL(TOL), .BYTE_W(8), .SYNC_N(2)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_en   (start_en),
        .line_raw   (line_raw),
        .byte_out   (byte_out),
        .byte_valid (byte_valid),
        .abort_flag (abort_flag)
    );

    always @(negedge clk) begin
        if (byte_valid) begin
            cap[ncap % 4] = byte_out;
            ncap = ncap + 1;
            if (prev_v) pulse_bad = pulse_bad + 1;
        end
        prev_v = byte_valid;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic lvl, input int n);
        line_raw = lvl;
        repeat (n) @(negedge clk);
    endtask

    // Raw line: a 0 bit is raw high then low, a 1 bit raw low then high.
    task automatic send_bits(input logic [15:0] w, input int n, input int d);
        for (int i = 0; i < n; i++) begin
            logic b;
            b = w[n-1-i];
            drive(~b, (i == 0) ? HALF : HALF + d);
            drive(b, HALF);
        end
    endtask

    task automatic abort_and_clear(input string tag);
        drive(line_raw, HI + 10);
        chk(abort_flag == 1'b1, tag, abort_flag, 1);
        start_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(abort_flag == 1'b0, "R8 flag cleared on disable", abort_flag, 0);
        start_en = 1'b1;
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", ncap, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n0;
        repeat (5) @(negedge clk);
        chk(byte_out == 8'h00 && !byte_valid && !abort_flag, "R2 reset outputs",
            {byte_out, byte_valid, abort_flag}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Table walk: R1 R4 R5 R7 across data patterns and timing offsets
        start_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            logic [7:0] dat;
            int         d;
            dat = VEC[i][15:8];
            d   = int'($signed(VEC[i][7:0]));
            drive(1'b1, 20);
            n0 = ncap;
            send_bits({8'h00, dat}, 8, d);
            chk(ncap == n0 + 1, "R6 one strobe per byte", ncap - n0, 1);
            chk(cap[n0 % 4] == dat, "R1 R4 R7 decoded byte", cap[n0 % 4], dat);
            chk(abort_flag == 1'b0, "R4 no abort inside window", abort_flag, 0);
            abort_and_clear("R5 timeout after stream ends");
        end

        // R3: decoded falling edge in hunt does not arm
        start_en = 1'b0;
        drive(1'b0, 5);
        start_en = 1'b1;
        drive(1'b0, 5);
        n0 = ncap;
        drive(1'b1, HI + 20);
        chk(abort_flag == 1'b0, "R3 fall ignored in hunt", abort_flag, 0);
        send_bits(16'h004B, 8, 0);
        chk(ncap == n0 + 1 && cap[n0 % 4] == 8'h4B, "R3 armed by rise", cap[n0 % 4], 8'h4B);
        abort_and_clear("R5 timeout after R3 stream");

        // R4 late: edge one cycle past the window
        drive(1'b1, 20);
        n0 = ncap;
        send_bits(16'h0000, 2, TOL + 1);
        chk(abort_flag == 1'b1, "R4 late edge aborts", abort_flag, 1);
        abort_and_clear("R5 late case");
        chk(ncap == n0, "R5 no byte after late edge", ncap - n0, 0);

        // R4 early: edge one cycle before the window is ignored
        drive(1'b1, 20);
        n0 = ncap;
        send_bits(16'h0000, 2, -TOL - 1);
        chk(abort_flag == 1'b1, "R4 early edge ignored then timeout", abort_flag, 1);
        abort_and_clear("R5 early case");

        // R8: partial byte discarded on disable
        drive(1'b1, 20);
        send_bits(16'h0006, 4, 0);
        start_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(abort_flag == 1'b0, "R8 no abort while off", abort_flag, 0);
        start_en = 1'b1;
        drive(1'b1, 20);
        n0 = ncap;
        send_bits(16'h0026, 8, 0);
        chk(ncap == n0 + 1 && cap[n0 % 4] == 8'h26, "R8 fresh byte after disable", cap[n0 % 4], 8'h26);
        abort_and_clear("R5 after R8");

        // R6: two consecutive bytes, second starts with a 1
        drive(1'b1, 20);
        n0 = ncap;
        send_bits(16'h3CC3, 16, 0);
        chk(ncap == n0 + 2, "R6 two strobes", ncap - n0, 2);
        chk(cap[n0 % 4] == 8'h3C, "R6 first byte", cap[n0 % 4], 8'h3C);
        chk(cap[(n0 + 1) % 4] == 8'hC3, "R6 second byte", cap[(n0 + 1) % 4], 8'hC3);

        // R9: flag stays set, decoder re-arms
        drive(line_raw, HI + 10);
        chk(abort_flag == 1'b1, "R9 abort set", abort_flag, 1);
        drive(1'b1, 20);
        n0 = ncap;
        send_bits(16'h0011, 8, 0);
        chk(ncap == n0 + 1 && cap[n0 % 4] == 8'h11, "R9 decode after abort", cap[n0 % 4], 8'h11);
        chk(abort_flag == 1'b1, "R9 flag sticky", abort_flag, 1);

        // R10: output holds
        drive(line_raw, 300);
        chk(byte_out == 8'h11, "R10 byte held", byte_out, 8'h11);
        chk(pulse_bad == 0, "R6 strobe width", pulse_bad, 0);

        // R2: activity while disabled
        start_en = 1'b0;
        drive(1'b1, 20);
        n0 = ncap;
        send_bits(16'h0055, 8, 0);
        drive(line_raw, HI + 10);
        chk(ncap == n0, "R2 no strobe while off", ncap - n0, 0);
        chk(abort_flag == 1'b0, "R2 no abort while off", abort_flag, 0);
        chk(byte_out == 8'h11, "R2 byte unchanged while off", byte_out, 8'h11);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule